// File: doc/BRIEF.md
# Interleaved ADC output demultiplexer

This block is the digital back end of a fast 8-bit converter. Once per rising edge of the sample clock it takes one quantized level, codes it in the selected number format and passes it through a fixed-latency pipeline. It then writes consecutive samples to two output ports in turn, so each port updates at half the sample rate. A data clock travels with the ports, and its rising edge marks the point where both ports hold a freshly written pair.

A sync input makes the ports and the data clock stop moving while it is high. When it falls, the next sample is tied to port A, so several devices driven by one sync line stay in the same port phase. A power-down input parks the outputs at zero and restarts the port phase. An enable can switch the data clock pair off. The format select is a four-level code. Only its format half affects the data path; the duty-cycle-stabilizer half is passed out as a flag.

The input level is a signed number with more bits than the output code. An in-range level L (from -128 to 127) stands for the quantized input, and anything outside that range is beyond full scale.

Top module: `ilv_adc_demux`

## Requirements
- R1: With offset binary selected (fmt_sel_i bit 1 = 1), an in-range level L is coded as L+128: -128 gives 0000_0000, 0 gives 1000_0000 and 127 gives 1111_1111.
- R2: A level below -128 is coded as the lowest code and a level above 127 as the highest code of the selected format (offset binary 0x00/0xFF, two's complement 0x80/0x7F).
- R3: With two's complement selected (fmt_sel_i bit 1 = 0), the code is the offset-binary code with its MSB inverted (-128 gives 0x80, 0 gives 0x00, 127 gives 0x7F). The format is taken at the edge where the sample is captured.
- R4: A sample captured on rising edge k is written to its port on rising edge k+8, and the port holds it until that port's next write.
- R5: Captured samples are assigned to port A and port B in strict alternation, and the two ports never change on the same edge.
- R6: On every edge where sync_i is high, the ports and the data clock keep their values, and no sample captured while sync_i is high, or captured before it rose and still in flight, ever reaches a port.
- R7: On the first edge N with sync_i low after an edge with sync_i high, the sample is assigned to port A, whatever the phase was before. It appears at edge N+8, the sample of edge N+1 appears on port B at N+9, and the alternation continues from there.
- R8: The internal data clock is low after each port A write and high after each port B write. With the enable high, dclk_o carries it and dclk_n_o carries its complement.
- R9: With dclk_en_i low, dclk_oe_o is 0 and dclk_o and dclk_n_o are both driven to the idle value 0; otherwise dclk_oe_o is 1.
- R10: stab_on_o is 1 for fmt_sel_i levels 2 and 1 and 0 for levels 3 and 0.
- R11: On every edge with pwdn_i high, both ports and the data clock go to 0, samples in flight are dropped and the phase returns to port A. After release, the first captured sample is written to port A 8 edges later.
- R12: While rst_ni is low, both ports and the data clock are 0. The first sample captured after release goes to port A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| lvl_i | input | LVL_W (10) | Signed quantized level; -128..127 is in range |
| fmt_sel_i | input | 2 | Level 3/2: offset binary, 1/0: two's complement; levels 2 and 1 request the stabilizer |
| sync_i | input | 1 | High freezes outputs; falling edge fixes port A phase |
| dclk_en_i | input | 1 | Data clock output enable |
| pwdn_i | input | 1 | Power-down: zero outputs, flush, reset phase |
| port_a_o | output | CODE_W (8) | Even-phase sample port |
| port_b_o | output | CODE_W (8) | Odd-phase sample port |
| dclk_o | output | 1 | Data clock, high after a port B write |
| dclk_n_o | output | 1 | Complement of the data clock |
| dclk_oe_o | output | 1 | Drive enable for the data clock pair |
| stab_on_o | output | 1 | Duty-cycle-stabilizer request decoded from fmt_sel_i |

## Verification
The bench builds the block with its defaults: a 10-bit level, an 8-bit code and a latency of 8. With these values it can sweep every in-range level in both formats and drive saturation out to the extreme levels -512 and 511 on both sides. The short pipeline lets the bench release sync and power-down with the phase left on either port. It can then watch each case until the first write lands, counting edge by edge.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Which output port a sample is steered to.
  typedef enum logic {
    PORT_A = 1'b0,
    PORT_B = 1'b1
  } port_e;

  // Bit of the format select level that chooses offset binary when set.
  localparam int FMT_OB_BIT = 1;

  function automatic port_e other_port(port_e p);
    return (p == PORT_A) ? PORT_B : PORT_A;
  endfunction

endpackage

// File: rtl/ilv_fmt.sv
// Saturating coder: signed level in, offset binary or two's complement out.
module ilv_fmt #(
  parameter int LVL_W  = 10,
  parameter int CODE_W = 8
) (
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              ob_i,
  output logic [CODE_W-1:0] code_o
);

  // Bits that must all equal the sign for the level to fit in CODE_W bits.
  localparam int TOP_W = LVL_W - CODE_W + 1;

  logic [TOP_W-1:0]  top_bits;
  logic              in_rng;
  logic [CODE_W-1:0] ob_code;

  always_comb begin
    top_bits = lvl_i[LVL_W-1:CODE_W-1];
    in_rng   = (&top_bits) | ~(|top_bits);
    if (in_rng) begin
      ob_code = {~lvl_i[CODE_W-1], lvl_i[CODE_W-2:0]};
    end else if (lvl_i[LVL_W-1]) begin
      ob_code = '0;
    end else begin
      ob_code = '1;
    end
    code_o = ob_i ? ob_code : {~ob_code[CODE_W-1], ob_code[CODE_W-2:0]};
  end

endmodule

// File: rtl/ilv_ctrl.sv
// Sync edge detection, flush decision and port phase tracking.
module ilv_ctrl
  import ilv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_i,
  input  logic  pwdn_i,
  output logic  cap_o,
  output logic  flush_o,
  output port_e tag_o
);

  logic  sync_q;
  port_e ph_q;
  port_e ph_d;
  logic  sync_fall;

  always_comb begin
    sync_fall = sync_q & ~sync_i;
    flush_o   = pwdn_i | sync_i;
    cap_o     = ~flush_o;
    tag_o     = sync_fall ? PORT_A : ph_q;
    if (pwdn_i) begin
      ph_d = PORT_A;
    end else if (cap_o) begin
      ph_d = other_port(tag_o);
    end else begin
      ph_d = ph_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      ph_q   <= PORT_A;
    end else begin
      sync_q <= sync_i;
      ph_q   <= ph_d;
    end
  end

endmodule

// File: rtl/ilv_pipe.sv
// Fixed-latency delay line carrying a valid flag, port tag and code.
module ilv_pipe
  import ilv_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LAT    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cap_i,
  input  port_e             tag_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              vld_o,
  output port_e             tag_o,
  output logic [CODE_W-1:0] code_o
);

  logic stg_en;
  assign stg_en = ~flush_i;

  for (genvar s = 0; s < LAT; s++) begin : g_stg
    logic              vld_q;
    port_e             tag_q;
    logic [CODE_W-1:0] code_q;
    logic              vld_d;
    port_e             tag_d;
    logic [CODE_W-1:0] code_d;

    if (s == 0) begin : g_head
      always_comb begin
        vld_d  = cap_i;
        tag_d  = tag_i;
        code_d = code_i;
      end
    end else begin : g_body
      always_comb begin
        vld_d  = g_stg[s-1].vld_q & ~flush_i;
        tag_d  = g_stg[s-1].tag_q;
        code_d = g_stg[s-1].code_q;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q  <= 1'b0;
        tag_q  <= PORT_A;
        code_q <= '0;
      end else begin
        vld_q <= vld_d;
        if (stg_en) begin
          tag_q  <= tag_d;
          code_q <= code_d;
        end
      end
    end
  end

  assign vld_o  = g_stg[LAT-1].vld_q;
  assign tag_o  = g_stg[LAT-1].tag_q;
  assign code_o = g_stg[LAT-1].code_q;

endmodule

// File: rtl/ilv_outp.sv
// Port registers and the internal data clock.
module ilv_outp
  import ilv_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwdn_i,
  input  logic              sync_i,
  input  logic              vld_i,
  input  port_e             tag_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] port_a_o,
  output logic [CODE_W-1:0] port_b_o,
  output logic              dclk_o
);

  logic [CODE_W-1:0] a_d;
  logic [CODE_W-1:0] b_d;
  logic              dclk_d;
  logic              wr_en;

  always_comb begin
    wr_en  = vld_i & ~sync_i;
    a_d    = port_a_o;
    b_d    = port_b_o;
    dclk_d = dclk_o;
    if (pwdn_i) begin
      a_d    = '0;
      b_d    = '0;
      dclk_d = 1'b0;
    end else if (wr_en) begin
      if (tag_i == PORT_A) begin
        a_d    = code_i;
        dclk_d = 1'b0;
      end else begin
        b_d    = code_i;
        dclk_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_a_o <= '0;
      port_b_o <= '0;
      dclk_o   <= 1'b0;
    end else begin
      port_a_o <= a_d;
      port_b_o <= b_d;
      dclk_o   <= dclk_d;
    end
  end

  a_r11_pwdn_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |=> (port_a_o == '0) && (port_b_o == '0) && !dclk_o);

  a_r6_sync_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !pwdn_i) |=> $stable(port_a_o) && $stable(port_b_o) && $stable(dclk_o));

  a_r5_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pwdn_i) |-> !(!$stable(port_a_o) && !$stable(port_b_o)));

endmodule

// File: rtl/ilv_adc_demux.sv
// Top: coder, control, delay line, port registers and data clock gating.
module ilv_adc_demux
  import ilv_pkg::*;
#(
  parameter int LVL_W  = 10,
  parameter int CODE_W = 8,
  parameter int LAT    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [1:0]        fmt_sel_i,
  input  logic              sync_i,
  input  logic              dclk_en_i,
  input  logic              pwdn_i,
  output logic [CODE_W-1:0] port_a_o,
  output logic [CODE_W-1:0] port_b_o,
  output logic              dclk_o,
  output logic              dclk_n_o,
  output logic              dclk_oe_o,
  output logic              stab_on_o
);

  logic [CODE_W-1:0] code_in;
  logic              cap;
  logic              flush;
  port_e             tag_in;
  logic              p_vld;
  port_e             p_tag;
  logic [CODE_W-1:0] p_code;
  logic              dclk_q;

  ilv_fmt #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_fmt (
    .lvl_i  (lvl_i),
    .ob_i   (fmt_sel_i[FMT_OB_BIT]),
    .code_o (code_in)
  );

  ilv_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .pwdn_i  (pwdn_i),
    .cap_o   (cap),
    .flush_o (flush),
    .tag_o   (tag_in)
  );

  ilv_pipe #(.CODE_W(CODE_W), .LAT(LAT)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .cap_i   (cap),
    .tag_i   (tag_in),
    .code_i  (code_in),
    .vld_o   (p_vld),
    .tag_o   (p_tag),
    .code_o  (p_code)
  );

  ilv_outp #(.CODE_W(CODE_W)) u_outp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwdn_i   (pwdn_i),
    .sync_i   (sync_i),
    .vld_i    (p_vld),
    .tag_i    (p_tag),
    .code_i   (p_code),
    .port_a_o (port_a_o),
    .port_b_o (port_b_o),
    .dclk_o   (dclk_q)
  );

  // Disabled clock pair idles at 0 on both lines.
  always_comb begin
    dclk_oe_o = dclk_en_i;
    dclk_o    = dclk_en_i & dclk_q;
    dclk_n_o  = dclk_en_i & ~dclk_q;
    stab_on_o = fmt_sel_i[1] ^ fmt_sel_i[0];
  end

  a_r8_low_after_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(port_a_o) && !$past(pwdn_i)) |-> !dclk_q);

  a_r8_high_after_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(port_b_o) && !$past(pwdn_i)) |-> dclk_q);

endmodule

// File: tb/ilv_adc_demux_tb.sv
`timescale 1ns/1ps
module ilv_adc_demux_tb_top;

  localparam int LVL_W  = 10;
  localparam int CODE_W = 8;
  localparam int LAT    = 8;
  localparam int HALF   = 1 << (CODE_W - 1);
  localparam int TOPC   = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [LVL_W-1:0]  lvl;
  logic [1:0]        fmt;
  logic              sync;
  logic              den;
  logic              pwdn;
  logic [CODE_W-1:0] port_a;
  logic [CODE_W-1:0] port_b;
  logic              dclk;
  logic              dclk_n;
  logic              dclk_oe;
  logic              stab;

  ilv_adc_demux #(.LVL_W(LVL_W), .CODE_W(CODE_W), .LAT(LAT)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .lvl_i     (lvl),
    .fmt_sel_i (fmt),
    .sync_i    (sync),
    .dclk_en_i (den),
    .pwdn_i    (pwdn),
    .port_a_o  (port_a),
    .port_b_o  (port_b),
    .dclk_o    (dclk),
    .dclk_n_o  (dclk_n),
    .dclk_oe_o (dclk_oe),
    .stab_on_o (stab)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur = "R12";
  bit    armed = 1'b0;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Codes per R1, R2 and R3.
  function automatic int ref_code(int l, bit ob);
    int c;
    if (l < -HALF)        c = 0;
    else if (l > HALF - 1) c = TOPC;
    else                   c = l + HALF;
    if (!ob) c = c ^ HALF;
    return c;
  endfunction

  // Expected port state, built from R4 to R7, R11 and R12.
  int ea = 0, eb = 0, ed = 0;
  int e = 0, last_fl = 0, eph = 0, k = 0, t = 0;
  bit sq = 1'b0;
  int hcode [16];
  int htag  [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; last_fl = 0; eph = 0; sq = 1'b0;
      ea = 0; eb = 0; ed = 0;
    end else begin
      e++;
      if (pwdn || sync) last_fl = e;
      if (pwdn) begin
        ea = 0; eb = 0; ed = 0; eph = 0;
      end else if (!sync) begin
        t = sq ? 0 : eph;
        eph = 1 - t;
        hcode[e % 16] = ref_code(int'($signed(lvl)), fmt[1]);
        htag[e % 16]  = t;
        k = e - LAT;
        if (k > last_fl) begin
          if (htag[k % 16] == 0) ea = hcode[k % 16];
          else                   eb = hcode[k % 16];
          ed = htag[k % 16];
        end
      end
      sq = sync;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(cur, int'(port_a), ea);
      chk(cur, int'(port_b), eb);
      chk("R8", int'(dclk),   den ? ed : 0);
      chk("R8", int'(dclk_n), den ? 1 - ed : 0);
      chk("R9", int'(dclk_oe), int'(den));
      chk("R10", int'(stab), int'(fmt[1] ^ fmt[0]));
    end
  end

  task automatic drive(int l);
    @(posedge clk);
    #1;
    lvl = LVL_W'(l);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL R4: watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; lvl = '0; fmt = 2'd3; sync = 1'b0; den = 1'b1; pwdn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    armed = 1'b1;                       // R12: reset state seen here
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) drive(i * 3 - 10);   // R12 first sample to A

    cur = "R1";
    for (int l = -HALF; l < HALF; l++) drive(l);

    cur = "R2";
    for (int l = -512; l < -HALF; l += 5) drive(l);
    for (int l = HALF; l < 512; l += 5) drive(l);
    drive(-512); drive(511); drive(-129); drive(128);

    cur = "R3";
    fmt = 2'd0;
    for (int l = -140; l <= 140; l++) drive(l);
    fmt = 2'd1;
    for (int l = -300; l <= 300; l += 7) drive(l);

    cur = "R5";
    fmt = 2'd3;
    for (int i = 0; i < 30; i++) drive((i * 37) % 256 - 128);

    cur = "R6";
    drive(11);
    sync = 1'b1;
    for (int i = 0; i < 6; i++) drive(40 + i);
    sync = 1'b0;
    for (int i = 0; i < 13; i++) drive(-60 + i * 9);

    cur = "R7";
    sync = 1'b1;
    drive(99);
    sync = 1'b0;
    for (int i = 0; i < 12; i++) drive(i * 10 - 50);
    drive(3);
    sync = 1'b1;
    drive(4);
    drive(5);
    sync = 1'b0;
    for (int i = 0; i < 14; i++) drive(-i * 8);

    cur = "R9";
    den = 1'b0;
    for (int i = 0; i < 20; i++) drive(i * 6);
    den = 1'b1;

    cur = "R10";
    for (int f = 3; f >= 0; f--) begin
      fmt = 2'(f);
      for (int i = 0; i < 5; i++) drive(i * 21 - 40);
    end
    fmt = 2'd3;

    cur = "R11";
    drive(7);
    pwdn = 1'b1;
    for (int i = 0; i < 10; i++) drive(70 + i);
    pwdn = 1'b0;
    for (int i = 0; i < 14; i++) drive(i * 5 - 30);

    cur = "R4";
    for (int i = 0; i < 20; i++) drive((i * 53) % 256 - 128);
    repeat (12) drive(0);
    @(negedge clk);
    #1;
    finish_run();
  end

endmodule